// File: doc/BRIEF.md
# Two-Wire Register Bank Slave with Auto-Increment

This block is a two-wire serial slave that holds a bank of nine 8-bit control registers, indexed 0 through 8. It runs on a fast system clock. The SCL and SDA lines are brought in through two-flop synchronizers, and the block drives SDA only by asserting an open-drain pull-down enable. The full register contents are also presented continuously on a flat parallel output, so that neighbouring logic can use the settings.

A write transaction carries the device address with the direction bit clear, then a command byte that selects a register, then any number of data bytes. Each data byte lands in the selected register and the pointer moves on by one.

A read transaction carries the device address with the direction bit set. It streams register contents from the current pointer until the master declines to acknowledge a byte. The pointer is a single value that survives from one transaction to the next. This gives four usable formats:

- A command byte with no data only moves the pointer.
- A bare read resumes wherever the pointer was left.
- A write of the command byte, followed by a repeated START and a read, gives random-access sequential reads.
- A write with data bytes updates consecutive registers.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset all nine registers read 0x00 on `regs_flat`, the pointer is 0, and `sda_pull` is 0 (SDA released).
- R2: The slave acknowledges (pulls SDA low during the ninth clock) only when the seven bits after START equal `DEV_ADDR`. On a mismatch it never pulls SDA and ignores every following byte until the next START.
- R3: A command byte with a value of 0 to 8 is acknowledged and loads the pointer, even when no data byte follows. A value of 9 or more is not acknowledged and leaves the pointer unchanged.
- R4: Each acknowledged data byte of a write is stored in the register at the pointer, and the pointer then advances by one. Register i occupies bits [8i+7:8i] of `regs_flat`.
- R5: A data byte that arrives while the pointer is past register 8 is not acknowledged and changes no register.
- R6: In a read, the slave sends the register at the pointer MSB first and advances the pointer after each byte. While the master acknowledges, it continues with the following registers.
- R7: A read with the pointer past register 8 returns 0xFF, and the pointer stays past the end.
- R8: A read that is not preceded by a command byte in the same transaction starts at the pointer left by the previous transaction.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START.
- R10: A START or STOP seen at any bit position aborts the transaction in progress. Register contents are unaffected, and a transaction that follows is served normally.
- R11: `sda_pull` rises only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_flat | output | NREG*DW (72) | All registers, register i at bits [8i+7:8i] |

## Verification
The bench builds the block with its defaults: nine 8-bit registers and device address 0x2A. With only nine registers, every starting pointer of a sequential read and every register of a write can be swept exhaustively, including the step past register 8. Data patterns are computed arithmetically, so each register holds a distinct value. The sweeps also cover:

- bare reads that continue from a pointer set in an earlier transaction
- command values out of range
- an address mismatch
- a START or STOP cut into the middle of a byte

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } rb_state_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_CMD,
        BK_DATA
    } rb_byte_e;
endpackage

// File: rtl/rb_sync.sv
module rb_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '1;
        end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/rb_busmon.sv
module rb_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign start    = scl & scl_q & sda_q & ~sda;
    assign stop     = scl & scl_q & ~sda_q & sda;
    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;
endmodule

// File: rtl/rb_regfile.sv
module rb_regfile #(
    parameter int NREG = 9,
    parameter int DW   = 8,
    parameter int PW   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PW-1:0]      waddr,
    input  logic [DW-1:0]      wdata,
    output logic [NREG*DW-1:0] flat
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        r_q <= '0;
            else if (we && waddr == PW'(i))    r_q <= wdata;
        end
        assign flat[i*DW +: DW] = r_q;
    end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter int          NREG     = 9,
    parameter int          DW       = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h2A,
    parameter int          SYNC     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    output logic [NREG*DW-1:0] regs_flat
);
    localparam int            PW       = $clog2(NREG + 1);
    localparam int            CW       = $clog2(DW + 1);
    localparam logic [PW-1:0] PTR_END  = PW'(NREG);
    localparam logic [DW-1:0] LAST_IDX = DW'(NREG - 1);
    localparam logic [CW-1:0] BITS     = CW'(DW);

    typedef struct packed {
        rb_state_e     st;
        rb_byte_e      kind;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic [PW-1:0] ptr;
        logic          oe;
        logic          rw;
        logic          mack;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic scl_s, sda_s, start, stop, scl_rise, scl_fall;
    logic we;
    logic [PW-1:0] waddr;
    logic [DW-1:0] wdata, rd_byte;

    rb_sync #(.STAGES(SYNC), .WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
    );

    rb_busmon u_mon (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .start(start), .stop(stop), .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    rb_regfile #(.NREG(NREG), .DW(DW), .PW(PW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .flat(regs_flat)
    );

    assign rd_byte = (ctl_q.ptr < PTR_END) ? regs_flat[int'(ctl_q.ptr)*DW +: DW] : '1;

    always_comb begin
        ctl_d = ctl_q;
        we    = 1'b0;
        waddr = ctl_q.ptr;
        wdata = ctl_q.sh;
        if (start) begin
            ctl_d.st   = ST_RX;
            ctl_d.kind = BK_ADDR;
            ctl_d.cnt  = '0;
            ctl_d.oe   = 1'b0;
        end else if (stop) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.cnt = '0;
            ctl_d.oe  = 1'b0;
        end else begin
            case (ctl_q.st)
                ST_RX: begin
                    if (scl_rise && ctl_q.cnt < BITS) begin
                        ctl_d.sh  = {ctl_q.sh[DW-2:0], sda_s};
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end else if (scl_fall && ctl_q.cnt == BITS) begin
                        ctl_d.cnt = '0;
                        ctl_d.st  = ST_IDLE;
                        case (ctl_q.kind)
                            BK_ADDR: if (ctl_q.sh[DW-1:1] == DEV_ADDR) begin
                                ctl_d.st = ST_ACK;
                                ctl_d.oe = 1'b1;
                                ctl_d.rw = ctl_q.sh[0];
                            end
                            BK_CMD: if (ctl_q.sh <= LAST_IDX) begin
                                ctl_d.st  = ST_ACK;
                                ctl_d.oe  = 1'b1;
                                ctl_d.ptr = ctl_q.sh[PW-1:0];
                            end
                            default: if (ctl_q.ptr < PTR_END) begin
                                we        = 1'b1;
                                ctl_d.st  = ST_ACK;
                                ctl_d.oe  = 1'b1;
                                ctl_d.ptr = ctl_q.ptr + 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK, ST_MACK: begin
                    if (ctl_q.st == ST_MACK && scl_rise) begin
                        ctl_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        ctl_d.oe  = 1'b0;
                        ctl_d.cnt = '0;
                        if (ctl_q.st == ST_MACK && !ctl_q.mack) begin
                            ctl_d.st = ST_IDLE;
                        end else if (ctl_q.st == ST_MACK || (ctl_q.kind == BK_ADDR && ctl_q.rw)) begin
                            ctl_d.st = ST_TX;
                            ctl_d.sh = rd_byte;
                            ctl_d.oe = ~rd_byte[DW-1];
                            if (ctl_q.ptr < PTR_END) ctl_d.ptr = ctl_q.ptr + 1'b1;
                        end else begin
                            ctl_d.st   = ST_RX;
                            ctl_d.kind = (ctl_q.kind == BK_ADDR) ? BK_CMD : BK_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (ctl_q.cnt == BITS) begin
                            ctl_d.oe   = 1'b0;
                            ctl_d.mack = 1'b0;
                            ctl_d.st   = ST_MACK;
                        end else begin
                            ctl_d.sh = {ctl_q.sh[DW-2:0], 1'b1};
                            ctl_d.oe = ~ctl_q.sh[DW-2];
                        end
                    end
                end
                default: ctl_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, kind: BK_ADDR, cnt: '0, sh: '0, ptr: '0,
                       oe: 1'b0, rw: 1'b0, mack: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_pull = ctl_q.oe;

    // R11: the pull-down is only switched on while SCL is low
    a_r11_pull_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);
    // R5: writes never address a register outside the bank
    a_r5_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr < PTR_END));
    // R4: the pointer never passes one beyond the last register
    a_r4_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.ptr <= PTR_END);
    // R4: an accepted data byte moves the pointer on by one
    a_r4_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ctl_q.ptr == $past(ctl_q.ptr) + 1'b1));
    // R9: when idle the slave never pulls SDA
    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE) |-> !sda_pull);
    // R10: a STOP returns the slave to idle with SDA released
    a_r10_stop_resets: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (ctl_q.st == ST_IDLE && !sda_pull));
endmodule

// File: tb/sim_i2c_regbank_slave.sv
`timescale 1ns/1ps
module sim_i2c_regbank_slave;
    localparam int NREG = 9;
    localparam int DW = 8;
    localparam logic [6:0] ADDR = 7'h2A;
    localparam int HALF = 200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull;
    logic [NREG*DW-1:0] regs_flat;
    wire  sda_line = sda_m & ~sda_pull;

    int checks = 0, failures = 0, viol = 0;
    logic [7:0] exp_r [NREG];
    logic prev_pull = 1'b0;

    always #5 clk = ~clk;

    i2c_regbank_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .regs_flat(regs_flat)
    );

    always @(negedge clk) begin
        if (sda_pull && !prev_pull && scl_m) viol++;
        prev_pull <= sda_pull;
    end

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [71:0] model_flat();
        logic [71:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = exp_r[i];
        return f;
    endfunction

    task automatic half(); #(HALF); endtask
    task automatic bus_start(); sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; half(); endtask
    task automatic bus_stop(); sda_m = 0; half(); scl_m = 1; half(); sda_m = 1; half(); endtask
    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; half(); scl_m = 1; half(); scl_m = 0; half();
        end
    endtask
    task automatic wr_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1; half(); scl_m = 1; half(); acked = ~sda_line; scl_m = 0; half();
    endtask
    task automatic rd_byte(input logic nack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            half(); scl_m = 1; half(); b[i] = sda_line; scl_m = 0;
        end
        sda_m = nack; half(); scl_m = 1; half(); scl_m = 0; half(); sda_m = 1;
    endtask
    task automatic rx_bare(input logic [7:0] expv, input string tag);
        logic a; logic [7:0] b;
        bus_start(); wr_byte({ADDR, 1'b1}, a); chk(tag, a, 1);
        rd_byte(1, b); chk(tag, b, expv); bus_stop();
    endtask
    task automatic set_ptr(input logic [7:0] p, input logic expack, input string tag);
        logic a;
        bus_start(); wr_byte({ADDR, 1'b0}, a); wr_byte(p, a); chk(tag, a, expack); bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] b;
        int ptr;
        #2;
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
        #100 rst_n = 1'b1;
        half();
        chk("R1 regs", regs_flat, 72'h0);
        chk("R1 pull", sda_pull, 0);
        rx_bare(exp_r[0], "R1 ptr0");

        // R4 / R5: one write burst across all registers and beyond
        bus_start();
        wr_byte({ADDR, 1'b0}, a); chk("R2 addr ack", a, 1);
        wr_byte(8'd0, a); chk("R3 cmd ack", a, 1);
        for (int i = 0; i < NREG; i++) begin
            exp_r[i] = 8'((i * 37 + 5) & 8'hFF);
            wr_byte(exp_r[i], a); chk("R4 data ack", a, 1);
        end
        wr_byte(8'hA5, a); chk("R5 past end nack", a, 0);
        bus_stop();
        chk("R4 burst contents", regs_flat, model_flat());

        // R6 / R7 / R9: sequential reads from every start pointer
        for (int p = 0; p < NREG; p++) begin
            bus_start(); wr_byte({ADDR, 1'b0}, a); wr_byte(8'(p), a);
            bus_start(); wr_byte({ADDR, 1'b1}, a); chk("R6 read addr ack", a, 1);
            for (int k = p; k < NREG; k++) begin
                rd_byte(0, b); chk("R6 seq read", b, exp_r[k]);
            end
            rd_byte(1, b); chk("R7 past end FF", b, 8'hFF);
            half(); chk("R9 released after nack", sda_pull, 0);
            bus_stop();
        end

        // R8: bare reads resume from the stored pointer
        rx_bare(8'hFF, "R7 R8 bare read past end");
        set_ptr(8'd4, 1, "R3 send-byte ack");
        rx_bare(exp_r[4], "R8 bare read at 4");
        rx_bare(exp_r[5], "R8 bare read advances");
        set_ptr(8'd12, 0, "R3 cmd out of range nack");
        rx_bare(exp_r[6], "R3 ptr kept");

        // R2: mismatching address is ignored
        bus_start(); wr_byte({ADDR ^ 7'h01, 1'b0}, a); chk("R2 mismatch nack", a, 0);
        wr_byte(8'd0, a); chk("R2 ignored cmd", a, 0);
        wr_byte(8'h77, a); chk("R2 ignored data", a, 0);
        bus_stop();
        chk("R2 regs unchanged", regs_flat, model_flat());
        rx_bare(exp_r[7], "R2 ptr unchanged");

        // R4: single-byte writes at every register
        for (int p = 0; p < NREG; p++) begin
            exp_r[p] = 8'((p * 91 + 17) & 8'hFF);
            bus_start(); wr_byte({ADDR, 1'b0}, a); wr_byte(8'(p), a);
            wr_byte(exp_r[p], a); chk("R4 single ack", a, 1); bus_stop();
        end
        chk("R4 single contents", regs_flat, model_flat());

        // R5: burst running off the end
        bus_start(); wr_byte({ADDR, 1'b0}, a); wr_byte(8'd7, a);
        exp_r[7] = 8'h3C; exp_r[8] = 8'hC6;
        wr_byte(8'h3C, a); chk("R5 reg7 ack", a, 1);
        wr_byte(8'hC6, a); chk("R5 reg8 ack", a, 1);
        wr_byte(8'h99, a); chk("R5 beyond nack", a, 0);
        bus_stop();
        chk("R5 contents", regs_flat, model_flat());

        // R10: START in mid-byte, then a normal write
        bus_start(); send_bits({ADDR, 1'b0}, 4);
        bus_start(); wr_byte({ADDR, 1'b0}, a); chk("R10 restart served", a, 1);
        wr_byte(8'd2, a); exp_r[2] = 8'hC3; wr_byte(8'hC3, a); bus_stop();
        chk("R10 write after restart", regs_flat, model_flat());
        // R10: STOP in mid data byte leaves register alone
        bus_start(); wr_byte({ADDR, 1'b0}, a); wr_byte(8'd3, a);
        send_bits(8'h00, 5); bus_stop();
        chk("R10 stop mid byte", regs_flat, model_flat());
        rx_bare(exp_r[3], "R10 read after abort");

        ptr = viol;
        chk("R11 pull rises with SCL low", ptr, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule